// File: doc/BRIEF.md
# Serial Control Word Receiver for a Stereo Tone and Volume Stage

This block takes control words from a host over a three-wire serial link (active-low select, serial clock, serial data) and keeps the setting registers of a stereo tone and volume stage. The registers are input select, bass, treble, master volume and four fader attenuations. All three serial pins are asynchronous to the system clock. Each pin passes through two flip-flops, and the block finds the serial edges in the system clock domain.

A frame lasts from the fall of select to its rise. The block checks a two-bit device address on the first two bits of the frame. It reads the function code and data from the final nine bits before select rises. Any number of filler bits may sit between the address and the payload. Data is clamped to the legal range of the addressed field before it is stored.

Top module: `audio_ctl_rx`

## Requirements
- R1: After reset, volume reads 40 (mute), every fader reads 20 (fully attenuated), bass and treble read 6 (flat) and input select reads 0.
- R2: The first two bits clocked after select falls must equal binary 10 (first bit 1, second bit 0). If they do not, the frame changes no register.
- R3: The payload is the last nine bits clocked before select rises. Filler bits between the address and the payload, of any count, have no effect.
- R4: A frame with fewer than 11 clocked bits when select rises changes no register.
- R5: Of the nine payload bits, the first three form the function code, MSB first. The code selects the target register: 0 input select, 1 bass, 2 treble, 3 volume, 4 right front fader, 5 left front fader, 6 right rear fader, 7 left rear fader. Only the addressed register changes.
- R6: A volume data value above 40 is stored as 40. Values from 0 to 40 are stored unchanged, in 2 dB attenuation steps.
- R7: A fader data value above 20 is stored as 20. Values from 0 to 20 are stored unchanged.
- R8: A bass or treble value above 12 is stored as 12. An input select value above 3 is stored as 3.
- R9: Registers change only as a result of a rise of select. The update is visible on the outputs at the third system clock edge after the select pin rises.
- R10: Data is sampled on the rising serial clock edge while select is low, MSB first, as the last six bits of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low, idle high |
| ser_clk | input | 1 | Serial clock, idle low |
| ser_dat | input | 1 | Serial data |
| in_sel | output | 2 | Selected stereo input |
| bass | output | 4 | Bass setting, 6 is flat |
| treble | output | 4 | Treble setting, 6 is flat |
| volume | output | 6 | Master attenuation in 2 dB steps, 40 is mute |
| fade_lf | output | 5 | Left front fader attenuation |
| fade_rf | output | 5 | Right front fader attenuation |
| fade_lr | output | 5 | Left rear fader attenuation |
| fade_rr | output | 5 | Right rear fader attenuation |

## Verification
The bench builds the block with its default parameters: device address 10, limits of 40, 20 and 12, and a flat tone value of 6. With six data bits these limits put every clamp boundary within reach: exactly at the limit, one above it, and the all-ones value. The bench also uses the default address to send frames with a wrong address, frames one bit short, and frames with many filler bits, which tests that the address and the payload are found at the two ends of the frame.

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx #(
  parameter logic [1:0] DEV_ADDR  = 2'b10,
  parameter int         VOL_MAX   = 40,
  parameter int         FADE_MAX  = 20,
  parameter int         TONE_MAX  = 12,
  parameter int         TONE_FLAT = 6,
  parameter int         SEL_MAX   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_sel_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic [1:0] in_sel,
  output logic [3:0] bass,
  output logic [3:0] treble,
  output logic [5:0] volume,
  output logic [4:0] fade_lf,
  output logic [4:0] fade_rf,
  output logic [4:0] fade_lr,
  output logic [4:0] fade_rr
);
  localparam int PAY_BITS   = 9;
  localparam int ADDR_BITS  = 2;
  localparam int FRAME_BITS = ADDR_BITS + PAY_BITS;
  localparam int CW         = $clog2(FRAME_BITS + 1);

  logic [1:0] sel_ff, sck_ff, dat_ff;
  logic       sel_q, sck_q;
  logic [PAY_BITS-1:0] shreg;
  logic [CW-1:0]       cnt;
  logic                addr_ok;

  wire sel_s    = sel_ff[1];
  wire sck_s    = sck_ff[1];
  wire dat_s    = dat_ff[1];
  wire sel_fall = sel_q & ~sel_s;
  wire sel_rise = ~sel_q & sel_s;
  wire sck_rise = ~sck_q & sck_s;
  wire take     = sel_rise & addr_ok & (cnt == CW'(FRAME_BITS));
  wire exp_bit  = (cnt == '0) ? DEV_ADDR[1] : DEV_ADDR[0];

  wire [2:0] code = shreg[8:6];
  wire [5:0] d    = shreg[5:0];
  wire [5:0] vol_c  = (d > 6'(VOL_MAX))  ? 6'(VOL_MAX)  : d;
  wire [4:0] fade_c = (d > 6'(FADE_MAX)) ? 5'(FADE_MAX) : d[4:0];
  wire [3:0] tone_c = (d > 6'(TONE_MAX)) ? 4'(TONE_MAX) : d[3:0];
  wire [1:0] sel_c  = (d > 6'(SEL_MAX))  ? 2'(SEL_MAX)  : d[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ff <= 2'b11;
      sck_ff <= 2'b00;
      dat_ff <= 2'b00;
      sel_q  <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      sel_ff <= {sel_ff[0], ser_sel_n};
      sck_ff <= {sck_ff[0], ser_clk};
      dat_ff <= {dat_ff[0], ser_dat};
      sel_q  <= sel_s;
      sck_q  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      addr_ok <= 1'b0;
    end else if (sel_fall) begin
      cnt     <= '0;
      addr_ok <= 1'b1;
    end else if (!sel_s && sck_rise) begin
      shreg <= {shreg[PAY_BITS-2:0], dat_s};
      if (cnt < CW'(ADDR_BITS) && dat_s != exp_bit) addr_ok <= 1'b0;
      if (cnt != CW'(FRAME_BITS)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sel  <= '0;
      bass    <= 4'(TONE_FLAT);
      treble  <= 4'(TONE_FLAT);
      volume  <= 6'(VOL_MAX);
      fade_lf <= 5'(FADE_MAX);
      fade_rf <= 5'(FADE_MAX);
      fade_lr <= 5'(FADE_MAX);
      fade_rr <= 5'(FADE_MAX);
    end else if (take) begin
      case (code)
        3'd0: in_sel  <= sel_c;
        3'd1: bass    <= tone_c;
        3'd2: treble  <= tone_c;
        3'd3: volume  <= vol_c;
        3'd4: fade_rf <= fade_c;
        3'd5: fade_lf <= fade_c;
        3'd6: fade_rr <= fade_c;
        default: fade_lr <= fade_c;
      endcase
    end
  end
endmodule

module audio_ctl_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_sel_n,
  input logic [1:0] in_sel,
  input logic [3:0] bass,
  input logic [3:0] treble,
  input logic [5:0] volume,
  input logic [4:0] fade_lf,
  input logic [4:0] fade_rf,
  input logic [4:0] fade_lr,
  input logic [4:0] fade_rr
);
  logic [2:0] sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], ser_sel_n};

  wire [34:0] all_out = {in_sel, bass, treble, volume, fade_lf, fade_rf, fade_lr, fade_rr};

  a_r9_only_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh[1] && !sh[2]) |=> $stable(all_out));
  a_r6_vol_limit: assert property (@(posedge clk) disable iff (!rst_n)
    volume <= 6'd40);
  a_r7_fade_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fade_lf <= 5'd20 && fade_rf <= 5'd20 && fade_lr <= 5'd20 && fade_rr <= 5'd20);
  a_r8_tone_limit: assert property (@(posedge clk) disable iff (!rst_n)
    bass <= 4'd12 && treble <= 4'd12);
endmodule

bind audio_ctl_rx audio_ctl_rx_chk chk (
  .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .in_sel(in_sel),
  .bass(bass), .treble(treble), .volume(volume), .fade_lf(fade_lf),
  .fade_rf(fade_rf), .fade_lr(fade_lr), .fade_rr(fade_rr)
);

// File: tb/audio_ctl_rx_test.sv
`timescale 1ns/1ps
module audio_ctl_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [1:0] in_sel;
  logic [3:0] bass, treble;
  logic [5:0] volume;
  logic [4:0] fade_lf, fade_rf, fade_lr, fade_rr;

  int vectors = 0, errors = 0;
  logic [1:0] e_sel = 0;
  logic [3:0] e_bass = 6, e_treb = 6;
  logic [5:0] e_vol = 40;
  logic [4:0] e_lf = 20, e_rf = 20, e_lr = 20, e_rr = 20;

  always #2.5 clk = ~clk;

  audio_ctl_rx uut (.*);

  task automatic cmp(string req, string f, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, f, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "in_sel", in_sel, e_sel);
    cmp(req, "bass", bass, e_bass);
    cmp(req, "treble", treble, e_treb);
    cmp(req, "volume", volume, e_vol);
    cmp(req, "fade_lf", fade_lf, e_lf);
    cmp(req, "fade_rf", fade_rf, e_rf);
    cmp(req, "fade_lr", fade_lr, e_lr);
    cmp(req, "fade_rr", fade_rr, e_rr);
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [1:0] a, int filler, logic [2:0] code, logic [5:0] d, bit short_by_one);
    logic [63:0] v = 64'(a);
    int n = 2 + filler + 9;
    for (int i = 0; i < filler; i++) v = {v[62:0], 1'(i)};
    v = (v << 9) | 64'({code, d});
    if (short_by_one) begin v = v >> 1; n = n - 1; end
    ser_sel_n = 1'b0; clocks(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i]; clocks(2);
      ser_clk = 1'b1; clocks(4);
      ser_clk = 1'b0; clocks(2);
    end
    ser_sel_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check_all("R1");
  endtask

  task automatic t_each_code;
    frame(2'b10, 0, 3'd3, 6'd10, 0); e_vol = 10;  check_all("R5 R9 volume");
    frame(2'b10, 0, 3'd0, 6'd2, 0);  e_sel = 2;   check_all("R5 input select");
    frame(2'b10, 0, 3'd1, 6'd9, 0);  e_bass = 9;  check_all("R5 bass");
    frame(2'b10, 0, 3'd2, 6'd3, 0);  e_treb = 3;  check_all("R5 treble");
    frame(2'b10, 0, 3'd4, 6'd1, 0);  e_rf = 1;    check_all("R5 right front");
    frame(2'b10, 0, 3'd5, 6'd5, 0);  e_lf = 5;    check_all("R5 left front");
    frame(2'b10, 0, 3'd6, 6'd11, 0); e_rr = 11;   check_all("R5 right rear");
    frame(2'b10, 0, 3'd7, 6'd17, 0); e_lr = 17;   check_all("R5 left rear");
  endtask

  task automatic t_clamps;
    frame(2'b10, 0, 3'd3, 6'd40, 0); e_vol = 40;  check_all("R6 at limit");
    frame(2'b10, 0, 3'd3, 6'd41, 0); e_vol = 40;  check_all("R6 above limit");
    frame(2'b10, 0, 3'd3, 6'd0, 0);  e_vol = 0;   check_all("R6 zero");
    frame(2'b10, 0, 3'd5, 6'd21, 0); e_lf = 20;   check_all("R7 above limit");
    frame(2'b10, 0, 3'd6, 6'd63, 0); e_rr = 20;   check_all("R7 all ones");
    frame(2'b10, 0, 3'd4, 6'd20, 0); e_rf = 20;   check_all("R7 at limit");
    frame(2'b10, 0, 3'd1, 6'd13, 0); e_bass = 12; check_all("R8 bass");
    frame(2'b10, 0, 3'd2, 6'd63, 0); e_treb = 12; check_all("R8 treble");
    frame(2'b10, 0, 3'd0, 6'd9, 0);  e_sel = 3;   check_all("R8 input select");
  endtask

  task automatic t_filler;
    frame(2'b10, 5, 3'd3, 6'd22, 0);  e_vol = 22; check_all("R3 five filler");
    frame(2'b10, 30, 3'd7, 6'd2, 0);  e_lr = 2;   check_all("R3 thirty filler");
    frame(2'b10, 1, 3'd0, 6'd1, 0);   e_sel = 1;  check_all("R10 msb first");
  endtask

  task automatic t_rejects;
    frame(2'b11, 0, 3'd3, 6'd7, 0); check_all("R2 addr 11");
    frame(2'b00, 3, 3'd3, 6'd7, 0); check_all("R2 addr 00");
    frame(2'b01, 0, 3'd1, 6'd1, 0); check_all("R2 addr 01");
    frame(2'b10, 0, 3'd3, 6'd7, 1); check_all("R4 ten bits");
  endtask

  task automatic t_idle_clock;
    for (int i = 0; i < 12; i++) begin
      ser_dat = 1'(i); clocks(2); ser_clk = 1'b1; clocks(3); ser_clk = 1'b0; clocks(2);
    end
    check_all("R10 idle clocks");
    frame(2'b10, 0, 3'd2, 6'd8, 0); e_treb = 8; check_all("R10 after idle clocks");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    clocks(4);
    rst_n = 1'b1;
    clocks(2);
    t_reset();
    t_each_code();
    t_clamps();
    t_filler();
    t_rejects();
    t_idle_clock();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule